// File: doc/BRIEF.md
# Per-source outstanding request tracker for a TL-UL link

This block sits beside a TL-UL link and watches both the request (A) and response (D) channels without driving any of their signals. It keeps one table entry per source ID. An entry becomes pending when a request on that ID completes its handshake. The entry records the request's opcode, size and byte mask. The entry is released when a response for that ID completes its handshake.

Each accepted response is checked against the entry it retires. Each accepted request is checked against the rule that an ID may have at most one request in flight. The first rule that is broken is latched into a sticky error register, together with a code and the source ID at fault. The register holds until it is cleared. An idle output reports that the table is empty, so a test can confirm at its end that every request was answered.

Top module: `tlul_src_tracker`

## Requirements
- R1: After reset no entry is pending, idle_o is 1, err_o is 0, and err_code_o and err_src_o are 0.
- R2: A request counts only when a_valid_i and a_ready_i are both high at a clock edge. It then marks its source entry pending and records the opcode and size. A request with a_ready_i low changes nothing.
- R3: A response counts only when d_valid_i and d_ready_i are both high. It clears the pending bit of d_source_i. idle_o is 1 exactly when no entry is pending, and it reflects handshakes from the previous clock edge.
- R4: Suppose a request and a response for the same ID complete in the same cycle. The response is then checked against the old entry. The entry stays pending with the new request's attributes, and no duplicate error is raised.
- R5: A request accepted on an ID that is already pending, and that is not retired in that same cycle, raises code 1.
- R6: A response accepted on an ID with no pending entry raises code 2.
- R7: If the stored opcode is Get (4), the response opcode must be AccessAckData (1). For any other stored opcode, including PutFullData (0) and PutPartialData (1), it must be AccessAck (0). Otherwise code 3 is raised.
- R8: A response whose d_size_i differs from the stored size raises code 4.
- R9: A response with a nonzero d_param_i raises code 5.
- R10: When several rules break in one cycle, the code reported is the first in this order: 2, 3, 4, 5, 1. err_src_o gives d_source_i for codes 2 to 5 and a_source_i for code 1.
- R11: Errors appear one cycle after the offending edge. Only the first violation is kept. Later ones leave err_o, err_code_o and err_src_o unchanged until clr_i is high. clr_i alone returns all three to 0. A violation in the same cycle as clr_i is latched in place of the old one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_valid_i | input | 1 | Request valid |
| a_ready_i | input | 1 | Request ready |
| a_opcode_i | input | 3 | Request opcode |
| a_size_i | input | SIZE_W | Request size (log2 bytes) |
| a_mask_i | input | MASK_W | Request byte mask |
| a_source_i | input | SRC_W | Request source ID |
| d_valid_i | input | 1 | Response valid |
| d_ready_i | input | 1 | Response ready |
| d_opcode_i | input | 3 | Response opcode |
| d_param_i | input | 3 | Response reserved field |
| d_size_i | input | SIZE_W | Response size |
| d_source_i | input | SRC_W | Response source ID |
| clr_i | input | 1 | Clears the sticky error |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Rule broken (0 when none) |
| err_src_o | output | SRC_W | Source ID of the latched violation |
| idle_o | output | 1 | No entry pending |

## Verification
The bench builds the block with SRC_W set to 2, which gives four entries. That is small enough to fill every entry of the table and drain it again, so idle_o is exercised at both the full and the empty boundary. SIZE_W is 2 and MASK_W is 4, which lets the size check compare all four sizes. The narrow source field also makes it cheap to collide a request and a response on one ID, and to pit a duplicate request against an orphan response in the same cycle to test the priority order.

// File: rtl/src_trk_pkg.sv
package src_trk_pkg;
  localparam int OP_W    = 3;
  localparam int PARAM_W = 3;
  localparam int CODE_W  = 3;

  localparam logic [OP_W-1:0] A_GET      = 3'd4;
  localparam logic [OP_W-1:0] D_ACK      = 3'd0;
  localparam logic [OP_W-1:0] D_ACK_DATA = 3'd1;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE   = 3'd0,
    ERR_DUP    = 3'd1,
    ERR_ORPHAN = 3'd2,
    ERR_OPCODE = 3'd3,
    ERR_SIZE   = 3'd4,
    ERR_PARAM  = 3'd5
  } err_code_e;
endpackage

// File: rtl/src_trk_table.sv
module src_trk_table
  import src_trk_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int SIZE_W = 2,
  parameter int MASK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_fire_i,
  input  logic [SRC_W-1:0]  a_src_i,
  input  logic [OP_W-1:0]   a_op_i,
  input  logic [SIZE_W-1:0] a_size_i,
  input  logic [MASK_W-1:0] a_mask_i,
  input  logic              d_fire_i,
  input  logic [SRC_W-1:0]  d_src_i,
  output logic [(1<<SRC_W)-1:0] pend_o,
  output logic              a_hit_o,
  output logic              d_pend_o,
  output logic [OP_W-1:0]   d_op_o,
  output logic [SIZE_W-1:0] d_size_o
);
  localparam int N = 1 << SRC_W;

  logic [N-1:0]      pend_q;
  logic [OP_W-1:0]   op_q   [N];
  logic [SIZE_W-1:0] size_q [N];
  logic [MASK_W-1:0] mask_q [N];
  logic [N-1:0]      set_w, clr_w;

  for (genvar k = 0; k < N; k++) begin : g_ent
    assign set_w[k] = a_fire_i && (a_src_i == SRC_W'(k));
    assign clr_w[k] = d_fire_i && (d_src_i == SRC_W'(k));

    // set wins over clear: same-ID request and response in one cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k] <= 1'b0;
        op_q[k]   <= '0;
        size_q[k] <= '0;
        mask_q[k] <= '0;
      end else if (set_w[k]) begin
        pend_q[k] <= 1'b1;
        op_q[k]   <= a_op_i;
        size_q[k] <= a_size_i;
        mask_q[k] <= a_mask_i;
      end else if (clr_w[k]) begin
        pend_q[k] <= 1'b0;
      end
    end

    p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[k] && !set_w[k]) |=> $stable(mask_q[k]));
  end

  assign pend_o   = pend_q;
  assign a_hit_o  = pend_q[a_src_i];
  assign d_pend_o = pend_q[d_src_i];
  assign d_op_o   = op_q[d_src_i];
  assign d_size_o = size_q[d_src_i];

  p_set_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire_i |=> pend_q[$past(a_src_i)]);

  p_retire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_fire_i && !(a_fire_i && a_src_i == d_src_i)) |=> !pend_q[$past(d_src_i)]);
endmodule

// File: rtl/src_trk_rules.sv
module src_trk_rules
  import src_trk_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int SIZE_W = 2
) (
  input  logic               a_fire_i,
  input  logic [SRC_W-1:0]   a_src_i,
  input  logic               a_hit_i,
  input  logic               d_fire_i,
  input  logic [SRC_W-1:0]   d_src_i,
  input  logic [OP_W-1:0]    d_op_i,
  input  logic [PARAM_W-1:0] d_param_i,
  input  logic [SIZE_W-1:0]  d_size_i,
  input  logic               d_pend_i,
  input  logic [OP_W-1:0]    d_stored_op_i,
  input  logic [SIZE_W-1:0]  d_stored_size_i,
  output logic               viol_o,
  output err_code_e          code_o,
  output logic [SRC_W-1:0]   src_o
);
  logic [OP_W-1:0] exp_op;
  logic            dup;

  assign exp_op = (d_stored_op_i == A_GET) ? D_ACK_DATA : D_ACK;
  // a slot freed by a same-cycle response may be reused
  assign dup = a_fire_i && a_hit_i && !(d_fire_i && d_src_i == a_src_i);

  always_comb begin
    code_o = ERR_NONE;
    src_o  = d_src_i;
    if (d_fire_i) begin
      if (!d_pend_i)                        code_o = ERR_ORPHAN;
      else if (d_op_i != exp_op)            code_o = ERR_OPCODE;
      else if (d_size_i != d_stored_size_i) code_o = ERR_SIZE;
      else if (d_param_i != '0)             code_o = ERR_PARAM;
    end
    if (code_o == ERR_NONE && dup) begin
      code_o = ERR_DUP;
      src_o  = a_src_i;
    end
  end

  assign viol_o = (code_o != ERR_NONE);
endmodule

// File: rtl/src_trk_err.sv
module src_trk_err
  import src_trk_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             viol_i,
  input  err_code_e        code_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             err_o,
  output err_code_e        code_o,
  output logic [SRC_W-1:0] src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      code_o <= ERR_NONE;
      src_o  <= '0;
    end else if (viol_i && (clr_i || !err_o)) begin
      err_o  <= 1'b1;
      code_o <= code_i;
      src_o  <= src_i;
    end else if (clr_i) begin
      err_o  <= 1'b0;
      code_o <= ERR_NONE;
      src_o  <= '0;
    end
  end

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> (err_o && $stable(code_o) && $stable(src_o)));

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !viol_i) |=> !err_o);
endmodule

// File: rtl/tlul_src_tracker.sv
module tlul_src_tracker
  import src_trk_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int SIZE_W = 2,
  parameter int MASK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_valid_i,
  input  logic              a_ready_i,
  input  logic [2:0]        a_opcode_i,
  input  logic [SIZE_W-1:0] a_size_i,
  input  logic [MASK_W-1:0] a_mask_i,
  input  logic [SRC_W-1:0]  a_source_i,
  input  logic              d_valid_i,
  input  logic              d_ready_i,
  input  logic [2:0]        d_opcode_i,
  input  logic [2:0]        d_param_i,
  input  logic [SIZE_W-1:0] d_size_i,
  input  logic [SRC_W-1:0]  d_source_i,
  input  logic              clr_i,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic [SRC_W-1:0]  err_src_o,
  output logic              idle_o
);
  localparam int N = 1 << SRC_W;

  logic              a_fire, d_fire, a_hit, d_pend, viol;
  logic [N-1:0]      pend;
  logic [OP_W-1:0]   d_stored_op;
  logic [SIZE_W-1:0] d_stored_size;
  logic [SRC_W-1:0]  viol_src;
  err_code_e         viol_code, err_code;

  assign a_fire = a_valid_i && a_ready_i;
  assign d_fire = d_valid_i && d_ready_i;

  src_trk_table #(.SRC_W(SRC_W), .SIZE_W(SIZE_W), .MASK_W(MASK_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_fire_i (a_fire),
    .a_src_i  (a_source_i),
    .a_op_i   (a_opcode_i),
    .a_size_i (a_size_i),
    .a_mask_i (a_mask_i),
    .d_fire_i (d_fire),
    .d_src_i  (d_source_i),
    .pend_o   (pend),
    .a_hit_o  (a_hit),
    .d_pend_o (d_pend),
    .d_op_o   (d_stored_op),
    .d_size_o (d_stored_size)
  );

  src_trk_rules #(.SRC_W(SRC_W), .SIZE_W(SIZE_W)) u_rules (
    .a_fire_i        (a_fire),
    .a_src_i         (a_source_i),
    .a_hit_i         (a_hit),
    .d_fire_i        (d_fire),
    .d_src_i         (d_source_i),
    .d_op_i          (d_opcode_i),
    .d_param_i       (d_param_i),
    .d_size_i        (d_size_i),
    .d_pend_i        (d_pend),
    .d_stored_op_i   (d_stored_op),
    .d_stored_size_i (d_stored_size),
    .viol_o          (viol),
    .code_o          (viol_code),
    .src_o           (viol_src)
  );

  src_trk_err #(.SRC_W(SRC_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .viol_i (viol),
    .code_i (viol_code),
    .src_i  (viol_src),
    .err_o  (err_o),
    .code_o (err_code),
    .src_o  (err_src_o)
  );

  assign err_code_o = err_code;
  assign idle_o     = ~|pend;

  p_code_nonzero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 3'd0));

  p_orphan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_fire && idle_o && !err_o) |=> (err_o && err_code_o == 3'd2));
endmodule

// File: tb/tlul_src_tracker_tb.sv
`timescale 1ns/1ps
module tlul_src_tracker_tb;
  localparam int SW = 2;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, a_ready = 0, d_valid = 0, d_ready = 0, clr = 0;
  logic [2:0] a_op = 0, d_op = 0, d_param = 0;
  logic [1:0] a_size = 0, d_size = 0;
  logic [3:0] a_mask = 0;
  logic [SW-1:0] a_src = 0, d_src = 0;
  logic err;
  logic [2:0] err_code;
  logic [SW-1:0] err_src;
  logic idle;

  int checks = 0, errors = 0;
  string phase = "R1";

  bit m_pend[NS];
  int m_op[NS], m_sz[NS];
  int m_err = 0, m_code = 0, m_src = 0;

  always #2 clk = ~clk;

  tlul_src_tracker #(.SRC_W(SW), .SIZE_W(2), .MASK_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid), .a_ready_i(a_ready), .a_opcode_i(a_op),
    .a_size_i(a_size), .a_mask_i(a_mask), .a_source_i(a_src),
    .d_valid_i(d_valid), .d_ready_i(d_ready), .d_opcode_i(d_op),
    .d_param_i(d_param), .d_size_i(d_size), .d_source_i(d_src),
    .clr_i(clr), .err_o(err), .err_code_o(err_code), .err_src_o(err_src),
    .idle_o(idle)
  );

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int code = 0;
    int src = 0;
    bit af = a_valid && a_ready;
    bit df = d_valid && d_ready;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_pend[i] = 0;
      m_err = 0; m_code = 0; m_src = 0;
      return;
    end
    if (df) begin
      if (!m_pend[d_src]) code = 2;
      else if (int'(d_op) != ((m_op[d_src] == 4) ? 1 : 0)) code = 3;
      else if (int'(d_size) != m_sz[d_src]) code = 4;
      else if (d_param != 0) code = 5;
      src = d_src;
    end
    if (code == 0 && af && m_pend[a_src] && !(df && d_src == a_src)) begin
      code = 1; src = a_src;
    end
    if (code != 0 && (clr || m_err == 0)) begin
      m_err = 1; m_code = code; m_src = src;
    end else if (clr) begin
      m_err = 0; m_code = 0; m_src = 0;
    end
    if (df) m_pend[d_src] = 0;
    if (af) begin
      m_pend[a_src] = 1; m_op[a_src] = a_op; m_sz[a_src] = a_size;
    end
  endtask

  task automatic step();
    int busy = 0;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int i = 0; i < NS; i++) busy += m_pend[i];
    cmp("err_o", err, m_err);
    cmp("err_code_o", err_code, m_code);
    cmp("err_src_o", err_src, m_src);
    cmp("idle_o", idle, (busy == 0) ? 1 : 0);
    a_valid = 0; a_ready = 0; d_valid = 0; d_ready = 0; clr = 0;
    d_param = 0; a_mask = 0;
  endtask

  task automatic req(int src, int op, int sz, bit rdy);
    a_valid = 1; a_ready = rdy; a_src = SW'(src); a_op = 3'(op);
    a_size = 2'(sz); a_mask = 4'hF;
  endtask

  task automatic rsp(int src, int op, int sz, int prm);
    d_valid = 1; d_ready = 1; d_src = SW'(src); d_op = 3'(op);
    d_size = 2'(sz); d_param = 3'(prm);
  endtask

  task automatic clear_err();
    clr = 1; step();
  endtask

  initial begin
    // R1: reset state, with reset held and just after release
    phase = "R1";
    step(); step();
    @(negedge clk) rst_n = 1;
    step();

    // R2: request ignored without ready, then accepted
    phase = "R2";
    req(0, 4, 2, 0); step();
    req(0, 4, 2, 1); step();
    // R3: retire with matching response
    phase = "R3";
    rsp(0, 1, 2, 0); step();
    step();
    // R3: fill every entry then drain in reverse
    for (int i = 0; i < NS; i++) begin req(i, i % 2, i, 1); step(); end
    for (int i = NS - 1; i >= 0; i--) begin rsp(i, 0, i, 0); step(); end

    // R4: same-ID request and response in one cycle
    phase = "R4";
    req(1, 0, 1, 1); step();
    rsp(1, 0, 1, 0); req(1, 4, 3, 1); step();
    rsp(1, 1, 3, 0); step();

    // R5: duplicate request
    phase = "R5";
    req(2, 1, 0, 1); step();
    req(2, 1, 0, 1); step();
    rsp(2, 0, 0, 0); clear_err();

    // R6: orphan response
    phase = "R6";
    rsp(3, 0, 0, 0); step();
    clear_err();

    // R7: opcode mismatch both ways
    phase = "R7";
    req(0, 4, 2, 1); step();
    rsp(0, 0, 2, 0); step();
    clear_err();
    req(0, 1, 2, 1); step();
    rsp(0, 1, 2, 0); step();
    clear_err();

    // R8: size mismatch
    phase = "R8";
    req(3, 0, 2, 1); step();
    rsp(3, 0, 1, 0); step();
    clear_err();

    // R9: nonzero reserved field
    phase = "R9";
    req(3, 4, 0, 1); step();
    rsp(3, 1, 0, 6); step();
    clear_err();

    // R10: orphan beats duplicate; opcode beats size
    phase = "R10";
    req(1, 0, 1, 1); step();
    req(1, 0, 1, 1); rsp(3, 0, 0, 0); step();
    clear_err();
    req(2, 0, 1, 1); step();
    rsp(2, 1, 3, 0); step();
    clear_err();
    rsp(1, 0, 1, 4); step();
    clear_err();

    // R11: first error kept, clear with new violation, clear alone
    phase = "R11";
    rsp(3, 0, 0, 0); step();
    rsp(2, 0, 0, 0); step();
    req(0, 0, 1, 1); step();
    rsp(0, 0, 1, 1); clr = 1; step();
    clear_err();
    step();

    // R3: table empty at the end
    phase = "R3";
    checks++;
    if (idle !== 1'b1) begin
      errors++;
      $display("FAIL R3 final idle_o actual=%0d expected=1", idle);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule